// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Product and Remainder Registers

This unit performs integer multiplication and division for a pipeline, working over several cycles and keeping its answers in two dedicated result registers, HI and LO, instead of the general register file. A start command names one of four operations on two operands: signed multiply, unsigned multiply, signed divide and unsigned divide. A multiply leaves the double-width product split across the pair. A divide leaves the quotient in LO and the remainder in HI.

The pipeline reads the results back with separate move-from requests, one register at a time. While an operation is in progress the unit raises `busy_o`. A read request made during that time is not answered until the result has been written, so the requester simply holds its request until the answer arrives. There is no overflow or trap output. Division by zero finishes normally and leaves fixed values.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and `busy_o` and `rd_valid_o` are low.
- R2: Operation code 0 (signed multiply) leaves the 64-bit two's-complement product of the operands, with its upper half in HI and its lower half in LO.
- R3: Operation code 1 (unsigned multiply) leaves the 64-bit unsigned product, with its upper half in HI and its lower half in LO.
- R4: Operation code 2 (signed divide) puts the quotient, truncated toward zero, in LO and the remainder, which has the sign of the dividend, in HI. The most negative dividend divided by -1 gives LO = 0x80000000 and HI = 0.
- R5: Operation code 3 (unsigned divide) puts the unsigned quotient in LO and the remainder in HI.
- R6: A divisor of zero completes without any error indication. HI takes the dividend. LO takes all ones, except for a signed divide of a negative dividend, where LO takes 1.
- R7: A start command is accepted only in a cycle where `busy_o` is low. From the next cycle, `busy_o` stays high for exactly W+1 cycles, and HI and LO are written on the edge at which it falls.
- R8: A start command given while `busy_o` is high is ignored. The running operation keeps its operands and its timing.
- R9: A read request (`rd_sel_i` = 1 selects HI, 0 selects LO) that is sampled while `busy_o` is low produces `rd_valid_o` one cycle later, with the register value on `rd_data_o`. While `busy_o` is high, no `rd_valid_o` is produced and the request is held off until the operation completes.
- R10: Reads never change HI or LO. The two registers change only when an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start an operation (taken only when not busy) |
| op_i | input | 2 | Operation: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| a_i | input | W | Multiplicand or dividend |
| b_i | input | W | Multiplier or divisor |
| rd_req_i | input | 1 | Move-from request, held until answered |
| rd_sel_i | input | 1 | Register to read: 1 for HI, 0 for LO |
| busy_o | output | 1 | Operation in progress |
| rd_valid_o | output | 1 | `rd_data_o` carries an answered read |
| rd_data_o | output | W | Value read from HI or LO |

## Verification
The bench targets the sign corners of the operations:
- Products of the most negative value with itself.
- Divides that mix operand signs. A design that takes the remainder's sign from the divisor, or rounds the quotient down, gives wrong HI or LO values.
- The most-negative-by-minus-one divide, which a non-wrapping design corrupts.

Divide by zero is checked for the exact values left in HI and LO. A design that skipped the magnitude correction would leave a different LO for negative dividends.

Further tests cover the following, and each exposes a timing defect:
- A start pulse in the middle of a running operation, which catches a unit that restarts.
- A read requested on the cycle after a start, which catches a unit that answers early with stale data.
- Repeated reads of the same register, which catch a read that disturbs the registers.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/mul_shift_add.sv
// Unsigned shift-add multiplier: one multiplier bit retired per step.
module mul_shift_add #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int AW = 2*W + 1;

  logic [AW-1:0] acc_q;
  logic [W-1:0]  mcand_q;
  logic [W:0]    upper_sum;
  logic [W:0]    upper_nxt;

  always_comb begin
    upper_sum = {1'b0, acc_q[2*W-1:W]} + {1'b0, mcand_q};
    upper_nxt = acc_q[0] ? upper_sum : {1'b0, acc_q[2*W-1:W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{(W+1){1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (step) begin
      acc_q   <= {1'b0, upper_nxt, acc_q[W-1:1]};
    end
  end

  assign prod = acc_q[2*W-1:0];
endmodule

// File: rtl/div_restore.sv
// Unsigned restoring divider: one quotient bit per step.
module div_restore #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~trial[W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd;
      dvs_q <= dvs;
    end else if (step) begin
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rd_req_i,
  input  logic         rd_sel_i,
  output logic         busy_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  md_state_e    st_q;
  logic [CW-1:0] cnt_q;
  md_op_e       op_q;
  logic         a_neg_q, b_neg_q;
  logic [W-1:0] hi_q, lo_q;
  logic         rd_valid_q;
  logic [W-1:0] rd_data_q;

  logic         accept, step, last, idle;
  logic         signed_op, a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;
  logic [2*W-1:0] prod_mag, prod_fix;
  logic [W-1:0] quo_mag, rem_mag, quo_fix, rem_fix;
  logic [W-1:0] hi_d, lo_d;

  assign idle   = (st_q == ST_IDLE);
  assign accept = start_i && idle;
  assign step   = (st_q == ST_RUN);
  assign last   = (cnt_q == CW'(W-1));

  // Operand conditioning: signed ops work on magnitudes.
  always_comb begin
    signed_op = (md_op_e'(op_i) == OP_MULS) || (md_op_e'(op_i) == OP_DIVS);
    a_neg     = signed_op && a_i[W-1];
    b_neg     = signed_op && b_i[W-1];
    a_mag     = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag     = b_neg ? (~b_i + 1'b1) : b_i;
  end

  mul_shift_add #(.W(W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .step   (step),
    .mcand  (a_mag),
    .mplier (b_mag),
    .prod   (prod_mag)
  );

  div_restore #(.W(W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .step (step),
    .dvd  (a_mag),
    .dvs  (b_mag),
    .quo  (quo_mag),
    .rem  (rem_mag)
  );

  // Sign restoration at completion.
  always_comb begin
    prod_fix = (a_neg_q ^ b_neg_q) ? (~prod_mag + 1'b1) : prod_mag;
    quo_fix  = (a_neg_q ^ b_neg_q) ? (~quo_mag + 1'b1) : quo_mag;
    rem_fix  = a_neg_q ? (~rem_mag + 1'b1) : rem_mag;
    if (op_q[1]) begin
      hi_d = rem_fix;
      lo_d = quo_fix;
    end else begin
      hi_d = prod_fix[2*W-1:W];
      lo_d = prod_fix[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_MULS;
      a_neg_q <= 1'b0;
      b_neg_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_RUN;
          cnt_q   <= '0;
          op_q    <= md_op_e'(op_i);
          a_neg_q <= a_neg;
          b_neg_q <= b_neg;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_FIN;
        end
        ST_FIN: begin
          hi_q <= hi_d;
          lo_q <= lo_d;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Move-from port: answered only while no operation is running.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req_i && idle;
      if (rd_req_i && idle) rd_data_q <= rd_sel_i ? hi_q : lo_q;
    end
  end

  assign busy_o     = !idle;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         rd_req_i,
  input logic         busy_o,
  input logic         rd_valid_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)         busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_cnt == CW'(W + 1)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && busy_cnt == CW'(W)) |=> !busy_o);

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && busy_o) |=> !rd_valid_o);

  p_valid_src_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_req_i && !busy_o));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_o) |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .rd_req_i   (rd_req_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .hi_q       (hi_q),
  .lo_q       (lo_q)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   op_i = 2'd0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         rd_req_i = 1'b0;
  logic         rd_sel_i = 1'b0;
  logic         busy_o;
  logic         rd_valid_o;
  logic [W-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  muldiv_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: {HI, LO} from the requirements.
  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'd0: begin p = 64'(sa * sb); return p; end
      2'd1: begin p = {32'b0, a} * {32'b0, b}; return p; end
      2'd2: begin
        if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  // Monitor: pops scoreboard entries as read answers appear.
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unrequested rd_valid", 64'(rd_data_o), 64'd0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, 64'(rd_data_o), 64'(e));
      end
    end
  end

  task automatic read_reg(input logic sel, input logic [W-1:0] exp, input string tag, output int waited);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_sel_i = sel;
    rd_req_i = 1'b1;
    waited = 0;
    forever begin
      @(negedge clk);
      waited++;
      if (rd_valid_o || waited > 200) break;
    end
    rd_req_i = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string tag, input bit poke);
    int n, w;
    logic [63:0] e;
    while (busy_o) @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n <= 100) begin
      n++;
      if (poke && n == 3) begin   // R8: start while busy must be ignored
        start_i = 1'b1; op_i = 2'd3; a_i = 32'd999; b_i = 32'd4;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == W + 1, poke ? "R8 busy length with extra start" : "R7 busy length",
          64'(n), 64'(W + 1));
    e = model(op, a, b);
    read_reg(1'b1, e[63:32], {tag, " HI"}, w);
    check(w == 1, "R9 idle read latency", 64'(w), 64'd1);
    read_reg(1'b0, e[31:0], {tag, " LO"}, w);
  endtask

  initial begin : main
    int w;
    logic [63:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
    check(rd_valid_o == 1'b0, "R1 rd_valid after reset", 64'(rd_valid_o), 64'd0);
    read_reg(1'b1, 32'd0, "R1 HI after reset", w);
    read_reg(1'b0, 32'd0, "R1 LO after reset", w);

    do_op(2'd0, -32'sd7, 32'd9, "R2 muls -7*9", 1'b0);
    do_op(2'd0, 32'h8000_0000, 32'h8000_0000, "R2 muls min*min", 1'b0);
    do_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 muls -1*-1", 1'b0);
    do_op(2'd0, 32'd12345, -32'sd678, "R2 muls mixed", 1'b0);

    do_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 mulu max*max", 1'b0);
    do_op(2'd1, 32'h8000_0000, 32'd2, "R3 mulu carry", 1'b0);
    do_op(2'd1, 32'd3, 32'd5, "R3 mulu small", 1'b0);

    do_op(2'd2, -32'sd7, 32'd2, "R4 divs -7/2", 1'b0);
    do_op(2'd2, 32'd7, -32'sd2, "R4 divs 7/-2", 1'b0);
    do_op(2'd2, -32'sd7, -32'sd2, "R4 divs -7/-2", 1'b0);
    do_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4 divs min/-1", 1'b0);
    do_op(2'd2, 32'd100, 32'd7, "R4 divs 100/7", 1'b0);

    do_op(2'd3, 32'hFFFF_FFFF, 32'd3, "R5 divu max/3", 1'b0);
    do_op(2'd3, 32'd5, 32'd9, "R5 divu small/large", 1'b0);
    do_op(2'd3, 32'h8000_0000, 32'h10, "R5 divu pow2", 1'b0);

    do_op(2'd3, 32'd77, 32'd0, "R6 divu by zero", 1'b0);
    do_op(2'd2, -32'sd5, 32'd0, "R6 divs neg by zero", 1'b0);
    do_op(2'd2, 32'd5, 32'd0, "R6 divs pos by zero", 1'b0);

    do_op(2'd0, 32'd1000, 32'd3000, "R8 first op kept", 1'b1);

    // R9: read requested right after start is held off until completion.
    while (busy_o) @(negedge clk);
    start_i = 1'b1; op_i = 2'd1; a_i = 32'hDEAD_BEEF; b_i = 32'h0001_0000;
    @(negedge clk);
    start_i = 1'b0;
    e = model(2'd1, 32'hDEAD_BEEF, 32'h0001_0000);
    read_reg(1'b1, e[63:32], "R9 stalled HI value", w);
    check(w == W + 2, "R9 stall latency", 64'(w), 64'(W + 2));

    // R10: repeated reads see unchanged registers.
    read_reg(1'b1, e[63:32], "R10 HI reread", w);
    read_reg(1'b1, e[63:32], "R10 HI reread again", w);
    read_reg(1'b0, e[31:0], "R10 LO reread", w);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 pending reads left", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule